// File: doc/BRIEF.md
# Interrupt Destination Mask Generator

This block resolves the target set of an inter-processor or message-signalled interrupt across a cluster of up to 32 local interrupt controllers. A request names an 8-bit destination, a physical/logical addressing bit, a 2-bit shorthand and the identity of the sending controller. The block matches these against a table that holds one entry per controller: a valid flag, a physical ID, a logical destination byte and a 4-bit logical model. The result is a target mask.

The mask is then distributed according to a 3-bit delivery mode. Fixed and lowest-priority requests drive per-target request bits, along with the vector and the trigger kind. SMI, NMI, INIT and startup requests drive per-target side-band pulses instead. A startup request stores its vector in each target's startup-vector register. An INIT de-assert request copies each target's physical ID into that target's arbitration-ID register. Every output is registered. The processor-side handling of each strobe is outside this block.

Table entries are written one at a time through a simple write port. A request that arrives in the same cycle as a table write is resolved against the table contents from before that write.

Top module: `intr_dest_mask`

## Requirements
- R1: Physical mode (`req_logical`=0, shorthand 0). Destination 8'hFF selects every valid controller. Any other value selects only the lowest-indexed valid controller whose physical ID equals the destination. If no valid controller has that ID, nothing is selected.
- R2: Logical mode with model field 4'hF (flat). A valid controller is selected when destination AND logical destination is nonzero.
- R3: Logical mode with model field 4'h0 (cluster). A valid controller is selected when the upper nibbles of destination and logical destination are equal and their lower nibbles share a set bit. A controller with any other model value never matches in logical mode.
- R4: Shorthand encoding. 0 uses the addressed mask. 1 selects only the sender. 2 selects all controllers. 3 selects all controllers except the sender. The destination and mode bit are ignored for shorthands 1 to 3.
- R5: A controller whose entry is invalid is never selected, in any mode or shorthand. Reset marks every entry invalid.
- R6: Delivery mode 3'd0 (fixed). `irq_hit` equals the mask. `irq_vector` and `irq_trigger` carry the request's vector and trigger bit.
- R7: Delivery mode 3'd1 (lowest priority). `irq_hit` holds only the lowest-indexed bit of the mask, and is zero if the mask is empty.
- R8: Delivery modes 3'd2 (SMI) and 3'd4 (NMI). `smi_pulse` or `nmi_pulse` respectively equals the mask, and `irq_hit` stays zero.
- R9: Delivery mode 3'd5 (INIT). When level=0 and trigger=1, no INIT pulse is raised and each selected target's arbitration ID is loaded with its physical ID, while other targets keep theirs. Otherwise `init_pulse` equals the mask.
- R10: Delivery mode 3'd6 (startup). `start_pulse` equals the mask and each selected target's startup vector is loaded with the request vector. Codes 3'd3 and 3'd7 raise nothing.
- R11: Outputs are registered. `dlv_valid` and the strobes appear exactly one cycle after `req_valid` and last one cycle. After reset all outputs are zero. A table write made in the same cycle as a request does not affect that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Index of the entry being written |
| tbl_valid | input | 1 | Valid flag for the written entry |
| tbl_phys_id | input | 8 | Physical ID for the written entry |
| tbl_log_dest | input | 8 | Logical destination for the written entry |
| tbl_model | input | 4 | Logical model (F flat, 0 cluster) |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_shorthand | input | 2 | Destination shorthand |
| req_sender | input | IDX_W | Index of the sending controller |
| req_mode | input | 3 | Delivery mode |
| req_vector | input | VEC_W | Interrupt or startup vector |
| req_trigger | input | 1 | Trigger kind (1 level) |
| req_level | input | 1 | Level bit (INIT assert/de-assert) |
| dlv_valid | output | 1 | Result valid, one cycle after request |
| irq_hit | output | N_CTRL | Per-target request bits (fixed/lowest) |
| irq_vector | output | VEC_W | Vector for the request bits |
| irq_trigger | output | 1 | Trigger kind for the request bits |
| smi_pulse | output | N_CTRL | Per-target SMI strobe |
| nmi_pulse | output | N_CTRL | Per-target NMI strobe |
| init_pulse | output | N_CTRL | Per-target INIT strobe |
| start_pulse | output | N_CTRL | Per-target startup strobe |
| start_vector_bus | output | N_CTRL*VEC_W | Latched startup vector per target |
| arb_id_bus | output | N_CTRL*8 | Arbitration ID per target |

## Verification
The bench probes several corner cases, each of which a specific bug would expose:
- Duplicate physical IDs. A design lacking the priority pick would deliver to two controllers.
- Mixed flat and cluster entries under one logical destination. A design that ignored the model field, or let the unknown model 4'h3 match, would add stray targets.
- An invalid entry reached by physical ID, by the self shorthand and by broadcast. A missing valid gate would make it fire.
- Lowest-priority delivery with the exclude-self shorthand and with an empty mask. A design that mixed these up would hit several targets, or the sender itself.
- INIT de-assert, checked through the arbitration-ID and startup-vector registers, including which entries must stay untouched.
- A request that coincides with a table write, which must be resolved against the old table contents.

// File: rtl/intr_dest_mask_pkg.sv
package intr_dest_mask_pkg;

  localparam int ID_W = 8;
  localparam int NIB_W = ID_W / 2;
  localparam int MODEL_W = 4;

  localparam logic [ID_W-1:0]    ID_BCAST      = '1;
  localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSV3   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_RSV7   = 3'd7
  } dlv_mode_e;

  typedef enum logic [1:0] {
    SH_ADDRESSED = 2'd0,
    SH_SELF      = 2'd1,
    SH_ALL       = 2'd2,
    SH_OTHERS    = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic               valid;
    logic [ID_W-1:0]    phys;
    logic [ID_W-1:0]    logd;
    logic [MODEL_W-1:0] model;
  } ctrl_entry_t;

endpackage

// File: rtl/idm_lowest.sv
module idm_lowest #(
  parameter int N = 32
) (
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] lowest_o
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  // two's-complement isolation of the least significant set bit
  assign lowest_o = bits_i & (~bits_i + ONE);
endmodule

// File: rtl/idm_table.sv
module idm_table
  import intr_dest_mask_pkg::*;
#(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  ctrl_entry_t           wr_entry,
  output ctrl_entry_t [N-1:0]   ent_o
);

  ctrl_entry_t [N-1:0] ent_q;
  ctrl_entry_t [N-1:0] ent_d;
  logic                wr_ok;

  assign wr_ok = wr_en && (int'(wr_idx) < N);

  always_comb begin
    ent_d = ent_q;
    for (int i = 0; i < N; i++) begin
      if (wr_ok && (int'(wr_idx) == i)) ent_d[i] = wr_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (wr_ok) begin
      ent_q <= ent_d;
    end
  end

  assign ent_o = ent_q;

  // R5
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (ent_q[$past(wr_idx)] == $past(wr_entry)));

endmodule

// File: rtl/idm_match.sv
module idm_match
  import intr_dest_mask_pkg::*;
#(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  ctrl_entry_t [N-1:0] ent_i,
  input  logic [ID_W-1:0]     dest_i,
  input  logic                logical_i,
  input  logic [1:0]          shorthand_i,
  input  logic [IDX_W-1:0]    sender_i,
  output logic [N-1:0]        mask_o,
  output logic [N-1:0]        valid_o
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] phys_hit;
  logic [N-1:0] log_hit;
  logic [N-1:0] phys_first;
  logic [N-1:0] addressed;
  logic [N-1:0] sender_oh;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic flat_m;
    logic clus_m;
    assign flat_m = (ent_i[i].model == MODEL_FLAT) && (|(dest_i & ent_i[i].logd));
    assign clus_m = (ent_i[i].model == MODEL_CLUSTER)
                 && (dest_i[ID_W-1:NIB_W] == ent_i[i].logd[ID_W-1:NIB_W])
                 && (|(dest_i[NIB_W-1:0] & ent_i[i].logd[NIB_W-1:0]));
    assign valid_o[i]  = ent_i[i].valid;
    assign phys_hit[i] = ent_i[i].valid && (ent_i[i].phys == dest_i);
    assign log_hit[i]  = ent_i[i].valid && (flat_m || clus_m);
  end

  idm_lowest #(.N(N)) u_phys_pick (
    .bits_i   (phys_hit),
    .lowest_o (phys_first)
  );

  assign sender_oh = ONE << sender_i;

  always_comb begin
    if (logical_i)                 addressed = log_hit;
    else if (dest_i == ID_BCAST)   addressed = valid_o;
    else                           addressed = phys_first;
  end

  always_comb begin
    unique case (shorthand_e'(shorthand_i))
      SH_ADDRESSED: mask_o = addressed;
      SH_SELF:      mask_o = valid_o & sender_oh;
      SH_ALL:       mask_o = valid_o;
      SH_OTHERS:    mask_o = valid_o & ~sender_oh;
      default:      mask_o = '0;
    endcase
  end

endmodule

// File: rtl/idm_fanout.sv
module idm_fanout
  import intr_dest_mask_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] mask_i,
  input  logic [2:0]   mode_i,
  input  logic         trigger_i,
  input  logic         level_i,
  output logic [N-1:0] irq_o,
  output logic [N-1:0] smi_o,
  output logic [N-1:0] nmi_o,
  output logic [N-1:0] init_o,
  output logic [N-1:0] start_o,
  output logic [N-1:0] arb_copy_o
);

  logic [N-1:0] low_mask;

  idm_lowest #(.N(N)) u_low_pick (
    .bits_i   (mask_i),
    .lowest_o (low_mask)
  );

  always_comb begin
    irq_o      = '0;
    smi_o      = '0;
    nmi_o      = '0;
    init_o     = '0;
    start_o    = '0;
    arb_copy_o = '0;
    unique case (dlv_mode_e'(mode_i))
      DM_FIXED:  irq_o   = mask_i;
      DM_LOWEST: irq_o   = low_mask;
      DM_SMI:    smi_o   = mask_i;
      DM_NMI:    nmi_o   = mask_i;
      DM_INIT: begin
        if (!level_i && trigger_i) arb_copy_o = mask_i;
        else                       init_o     = mask_i;
      end
      DM_START:  start_o = mask_i;
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/intr_dest_mask.sv
module intr_dest_mask
  import intr_dest_mask_pkg::*;
#(
  parameter int N_CTRL = 32,
  parameter int VEC_W  = 8,
  parameter int IDX_W  = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tbl_we,
  input  logic [IDX_W-1:0]        tbl_idx,
  input  logic                    tbl_valid,
  input  logic [7:0]              tbl_phys_id,
  input  logic [7:0]              tbl_log_dest,
  input  logic [3:0]              tbl_model,
  input  logic                    req_valid,
  input  logic [7:0]              req_dest,
  input  logic                    req_logical,
  input  logic [1:0]              req_shorthand,
  input  logic [IDX_W-1:0]        req_sender,
  input  logic [2:0]              req_mode,
  input  logic [VEC_W-1:0]        req_vector,
  input  logic                    req_trigger,
  input  logic                    req_level,
  output logic                    dlv_valid,
  output logic [N_CTRL-1:0]       irq_hit,
  output logic [VEC_W-1:0]        irq_vector,
  output logic                    irq_trigger,
  output logic [N_CTRL-1:0]       smi_pulse,
  output logic [N_CTRL-1:0]       nmi_pulse,
  output logic [N_CTRL-1:0]       init_pulse,
  output logic [N_CTRL-1:0]       start_pulse,
  output logic [N_CTRL*VEC_W-1:0] start_vector_bus,
  output logic [N_CTRL*ID_W-1:0]  arb_id_bus
);

  ctrl_entry_t [N_CTRL-1:0] entries;
  ctrl_entry_t              wr_entry;
  logic [N_CTRL-1:0]        sel_mask;
  logic [N_CTRL-1:0]        valid_vec;
  logic [N_CTRL-1:0]        f_irq, f_smi, f_nmi, f_init, f_start, f_arb;

  assign wr_entry = '{valid: tbl_valid, phys: tbl_phys_id,
                      logd: tbl_log_dest, model: tbl_model};

  idm_table #(.N(N_CTRL), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_idx),
    .wr_entry (wr_entry),
    .ent_o    (entries)
  );

  idm_match #(.N(N_CTRL), .IDX_W(IDX_W)) u_match (
    .ent_i       (entries),
    .dest_i      (req_dest),
    .logical_i   (req_logical),
    .shorthand_i (req_shorthand),
    .sender_i    (req_sender),
    .mask_o      (sel_mask),
    .valid_o     (valid_vec)
  );

  idm_fanout #(.N(N_CTRL)) u_fanout (
    .mask_i     (sel_mask),
    .mode_i     (req_mode),
    .trigger_i  (req_trigger),
    .level_i    (req_level),
    .irq_o      (f_irq),
    .smi_o      (f_smi),
    .nmi_o      (f_nmi),
    .init_o     (f_init),
    .start_o    (f_start),
    .arb_copy_o (f_arb)
  );

  // pulse outputs: next state and registers
  logic                 valid_d, valid_q;
  logic [N_CTRL-1:0]    irq_d, irq_q, smi_d, smi_q, nmi_d, nmi_q;
  logic [N_CTRL-1:0]    init_d, init_q, start_d, start_q;
  logic [VEC_W-1:0]     vec_d, vec_q;
  logic                 trig_d, trig_q;

  always_comb begin
    valid_d = req_valid;
    irq_d   = req_valid ? f_irq   : '0;
    smi_d   = req_valid ? f_smi   : '0;
    nmi_d   = req_valid ? f_nmi   : '0;
    init_d  = req_valid ? f_init  : '0;
    start_d = req_valid ? f_start : '0;
    vec_d   = vec_q;
    trig_d  = trig_q;
    if (req_valid && (|f_irq)) begin
      vec_d  = req_vector;
      trig_d = req_trigger;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      irq_q   <= '0;
      smi_q   <= '0;
      nmi_q   <= '0;
      init_q  <= '0;
      start_q <= '0;
      vec_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      irq_q   <= irq_d;
      smi_q   <= smi_d;
      nmi_q   <= nmi_d;
      init_q  <= init_d;
      start_q <= start_d;
      vec_q   <= vec_d;
      trig_q  <= trig_d;
    end
  end

  // per-target persistent registers with explicit enables
  for (genvar i = 0; i < N_CTRL; i++) begin : g_tgt
    logic             sv_en, arb_en;
    logic [VEC_W-1:0] sv_q;
    logic [ID_W-1:0]  arb_q;

    assign sv_en  = req_valid && f_start[i];
    assign arb_en = req_valid && f_arb[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sv_q <= '0;
      else if (sv_en)  sv_q <= req_vector;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      arb_q <= '0;
      else if (arb_en) arb_q <= entries[i].phys;
    end

    assign start_vector_bus[i*VEC_W +: VEC_W] = sv_q;
    assign arb_id_bus[i*ID_W +: ID_W]         = arb_q;
  end

  assign dlv_valid   = valid_q;
  assign irq_hit     = irq_q;
  assign irq_vector  = vec_q;
  assign irq_trigger = trig_q;
  assign smi_pulse   = smi_q;
  assign nmi_pulse   = nmi_q;
  assign init_pulse  = init_q;
  assign start_pulse = start_q;

  logic [N_CTRL-1:0] any_strobe;
  assign any_strobe = irq_q | smi_q | nmi_q | init_q | start_q;

  // R11
  req_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dlv_valid);

  // R11
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dlv_valid |-> (any_strobe == '0));

  // R7
  lowest_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_mode == DM_LOWEST)) |=> $onehot0(irq_hit));

  // R5
  invalid_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((any_strobe & ~$past(valid_vec)) == '0));

  // R4
  others_skip_sender_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_shorthand == SH_OTHERS))
      |=> (((any_strobe >> $past(req_sender)) & {{(N_CTRL-1){1'b0}}, 1'b1}) == '0));

  // R8
  one_family_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({|irq_q, |smi_q, |nmi_q, |init_q, |start_q}) <= 1);

endmodule

// File: tb/intr_dest_mask_test.sv
`timescale 1ns/1ps
module intr_dest_mask_test;

  localparam int N = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic tbl_we, tbl_valid;
  logic [IW-1:0] tbl_idx;
  logic [7:0] tbl_phys_id, tbl_log_dest;
  logic [3:0] tbl_model;
  logic req_valid, req_logical, req_trigger, req_level;
  logic [7:0] req_dest, req_vector;
  logic [1:0] req_shorthand;
  logic [IW-1:0] req_sender;
  logic [2:0] req_mode;
  logic dlv_valid, irq_trigger;
  logic [N-1:0] irq_hit, smi_pulse, nmi_pulse, init_pulse, start_pulse;
  logic [7:0] irq_vector;
  logic [N*8-1:0] start_vector_bus, arb_id_bus;

  always #2.5 clk = ~clk;

  intr_dest_mask uut (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
    .tbl_phys_id(tbl_phys_id), .tbl_log_dest(tbl_log_dest), .tbl_model(tbl_model),
    .req_valid(req_valid), .req_dest(req_dest), .req_logical(req_logical),
    .req_shorthand(req_shorthand), .req_sender(req_sender), .req_mode(req_mode),
    .req_vector(req_vector), .req_trigger(req_trigger), .req_level(req_level),
    .dlv_valid(dlv_valid), .irq_hit(irq_hit), .irq_vector(irq_vector),
    .irq_trigger(irq_trigger), .smi_pulse(smi_pulse), .nmi_pulse(nmi_pulse),
    .init_pulse(init_pulse), .start_pulse(start_pulse),
    .start_vector_bus(start_vector_bus), .arb_id_bus(arb_id_bus)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr_tbl(input int idx, input logic v, input logic [7:0] ph,
                        input logic [7:0] ld, input logic [3:0] md);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_valid = v;
    tbl_phys_id = ph; tbl_log_dest = ld; tbl_model = md;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic set_req(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                         input logic [4:0] snd, input logic [2:0] md,
                         input logic [7:0] vc, input logic tr, input logic lv);
    req_dest = d; req_logical = lg; req_shorthand = sh; req_sender = snd;
    req_mode = md; req_vector = vc; req_trigger = tr; req_level = lv;
    req_valid = 1'b1;
  endtask

  // drive at a falling edge; return at the next falling edge, after the register stage
  task automatic send(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                      input logic [4:0] snd, input logic [2:0] md,
                      input logic [7:0] vc, input logic tr, input logic lv);
    @(negedge clk);
    set_req(d, lg, sh, snd, md, vc, tr, lv);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // {tag4, dest8, logical1, shorthand2, sender5, mode3, vector8, trig1, level1, mask32}
  localparam int NV = 21;
  localparam logic [64:0] VEC [NV] = '{
    {4'd1,  8'hFF, 1'b0, 2'd0, 5'd0, 3'd0, 8'h41, 1'b0, 1'b1, 32'h0000_00FF}, // R1 broadcast
    {4'd1,  8'h12, 1'b0, 2'd0, 5'd0, 3'd0, 8'h42, 1'b0, 1'b1, 32'h0000_0004}, // R1 duplicate id
    {4'd1,  8'h33, 1'b0, 2'd0, 5'd0, 3'd0, 8'h43, 1'b0, 1'b1, 32'h0000_0000}, // R1 no match
    {4'd5,  8'h18, 1'b0, 2'd0, 5'd0, 3'd0, 8'h44, 1'b0, 1'b1, 32'h0000_0000}, // R5 invalid id
    {4'd2,  8'h03, 1'b1, 2'd0, 5'd0, 3'd0, 8'h45, 1'b0, 1'b1, 32'h0000_0043}, // R2 flat
    {4'd3,  8'h83, 1'b1, 2'd0, 5'd0, 3'd0, 8'h46, 1'b0, 1'b1, 32'h0000_005B}, // R3 cluster 8
    {4'd3,  8'h92, 1'b1, 2'd0, 5'd0, 3'd0, 8'h47, 1'b0, 1'b1, 32'h0000_0062}, // R3 cluster 9
    {4'd4,  8'hFF, 1'b0, 2'd1, 5'd4, 3'd0, 8'h48, 1'b0, 1'b1, 32'h0000_0010}, // R4 self
    {4'd4,  8'h33, 1'b1, 2'd2, 5'd0, 3'd0, 8'h49, 1'b0, 1'b1, 32'h0000_00FF}, // R4 all
    {4'd4,  8'h00, 1'b0, 2'd3, 5'd1, 3'd0, 8'h4A, 1'b0, 1'b1, 32'h0000_00FD}, // R4 others
    {4'd5,  8'h00, 1'b0, 2'd1, 5'd9, 3'd0, 8'h4B, 1'b0, 1'b1, 32'h0000_0000}, // R5 invalid self
    {4'd7,  8'h92, 1'b1, 2'd0, 5'd0, 3'd1, 8'h4C, 1'b0, 1'b1, 32'h0000_0002}, // R7 logical
    {4'd7,  8'h00, 1'b0, 2'd3, 5'd0, 3'd1, 8'h4D, 1'b0, 1'b1, 32'h0000_0002}, // R7 others
    {4'd7,  8'h33, 1'b0, 2'd0, 5'd0, 3'd1, 8'h4E, 1'b0, 1'b1, 32'h0000_0000}, // R7 empty
    {4'd8,  8'h00, 1'b0, 2'd2, 5'd0, 3'd2, 8'h4F, 1'b0, 1'b1, 32'h0000_00FF}, // R8 smi
    {4'd8,  8'h03, 1'b1, 2'd0, 5'd0, 3'd4, 8'h50, 1'b0, 1'b1, 32'h0000_0043}, // R8 nmi
    {4'd9,  8'hFF, 1'b0, 2'd0, 5'd0, 3'd5, 8'h51, 1'b0, 1'b1, 32'h0000_00FF}, // R9 init assert
    {4'd9,  8'h00, 1'b0, 2'd1, 5'd3, 3'd5, 8'h52, 1'b1, 1'b1, 32'h0000_0008}, // R9 init level
    {4'd10, 8'h00, 1'b0, 2'd2, 5'd0, 3'd3, 8'h53, 1'b0, 1'b1, 32'h0000_0000}, // R10 code 3
    {4'd10, 8'h00, 1'b0, 2'd2, 5'd0, 3'd7, 8'h54, 1'b0, 1'b1, 32'h0000_0000}, // R10 code 7
    {4'd6,  8'h15, 1'b0, 2'd0, 5'd0, 3'd0, 8'hEE, 1'b1, 1'b1, 32'h0000_0020}  // R6 fixed level
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tbl_we = 0; tbl_idx = '0; tbl_valid = 0; tbl_phys_id = 0; tbl_log_dest = 0; tbl_model = 0;
    req_valid = 0; req_dest = 0; req_logical = 0; req_shorthand = 0; req_sender = '0;
    req_mode = 0; req_vector = 0; req_trigger = 0; req_level = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset dlv_valid", 32'(dlv_valid), 32'h0);
    chk("R11", "reset strobes", irq_hit | smi_pulse | nmi_pulse | init_pulse | start_pulse, 32'h0);
    chk("R11", "reset arb ids", arb_id_bus[31:0], 32'h0);
    rst_n = 1'b1;

    // R5: empty table after reset, broadcast shorthand hits nobody
    send(8'h00, 1'b0, 2'd2, 5'd0, 3'd0, 8'h20, 1'b0, 1'b1);
    chk("R5", "empty table irq_hit", irq_hit, 32'h0);
    chk("R11", "valid after request", 32'(dlv_valid), 32'h1);

    wr_tbl(0, 1'b1, 8'h10, 8'h01, 4'hF);
    wr_tbl(1, 1'b1, 8'h11, 8'h02, 4'hF);
    wr_tbl(2, 1'b1, 8'h12, 8'h04, 4'hF);
    wr_tbl(3, 1'b1, 8'h13, 8'h81, 4'h0);
    wr_tbl(4, 1'b1, 8'h14, 8'h82, 4'h0);
    wr_tbl(5, 1'b1, 8'h15, 8'h92, 4'h0);
    wr_tbl(6, 1'b1, 8'h12, 8'h06, 4'hF);
    wr_tbl(7, 1'b1, 8'h17, 8'hFF, 4'h3);
    wr_tbl(8, 1'b0, 8'h18, 8'hFF, 4'hF);

    for (int k = 0; k < NV; k++) begin
      logic [64:0] v;
      logic [2:0] md;
      logic [31:0] m;
      string rq;
      v  = VEC[k];
      md = v[44:42];
      m  = v[31:0];
      rq = $sformatf("R%0d/vec%0d", v[64:61], k);
      send(v[60:53], v[52], v[51:50], v[49:45], md, v[41:34], v[33], v[32]);
      chk(rq, "dlv_valid", 32'(dlv_valid), 32'h1);
      chk(rq, "irq_hit", irq_hit, (md == 3'd0 || md == 3'd1) ? m : 32'h0);
      chk(rq, "smi_pulse", smi_pulse, (md == 3'd2) ? m : 32'h0);
      chk(rq, "nmi_pulse", nmi_pulse, (md == 3'd4) ? m : 32'h0);
      chk(rq, "init_pulse", init_pulse, (md == 3'd5) ? m : 32'h0);
      chk(rq, "start_pulse", start_pulse, (md == 3'd6) ? m : 32'h0);
      if ((md == 3'd0 || md == 3'd1) && m != 0) begin
        chk(rq, "irq_vector", 32'(irq_vector), 32'(v[41:34]));
        chk(rq, "irq_trigger", 32'(irq_trigger), 32'(v[33]));
      end
    end

    // R11 strobes last one cycle
    @(negedge clk);
    chk("R11", "idle dlv_valid", 32'(dlv_valid), 32'h0);
    chk("R11", "idle irq_hit", irq_hit, 32'h0);

    // R10 startup latches vectors for selected targets only
    send(8'h03, 1'b1, 2'd0, 5'd0, 3'd6, 8'h9A, 1'b0, 1'b1);
    chk("R10", "start_pulse", start_pulse, 32'h0000_0043);
    chk("R10", "start vec idx0", 32'(start_vector_bus[0*8 +: 8]), 32'h9A);
    chk("R10", "start vec idx6", 32'(start_vector_bus[6*8 +: 8]), 32'h9A);
    chk("R10", "start vec idx2", 32'(start_vector_bus[2*8 +: 8]), 32'h00);
    send(8'h00, 1'b0, 2'd1, 5'd2, 3'd6, 8'h5C, 1'b0, 1'b1);
    chk("R10", "start vec idx2 second", 32'(start_vector_bus[2*8 +: 8]), 32'h5C);
    chk("R10", "start vec idx0 kept", 32'(start_vector_bus[0*8 +: 8]), 32'h9A);

    // R9 INIT de-assert: no pulse, arbitration id copy
    send(8'h00, 1'b0, 2'd1, 5'd3, 3'd5, 8'h00, 1'b1, 1'b0);
    chk("R9", "deassert init_pulse", init_pulse, 32'h0);
    chk("R9", "arb id idx3", 32'(arb_id_bus[3*8 +: 8]), 32'h13);
    chk("R9", "arb id idx4 untouched", 32'(arb_id_bus[4*8 +: 8]), 32'h00);
    send(8'hFF, 1'b0, 2'd0, 5'd0, 3'd5, 8'h00, 1'b1, 1'b0);
    chk("R9", "arb id idx0", 32'(arb_id_bus[0*8 +: 8]), 32'h10);
    chk("R9", "arb id idx6", 32'(arb_id_bus[6*8 +: 8]), 32'h12);
    chk("R9", "arb id idx8 invalid", 32'(arb_id_bus[8*8 +: 8]), 32'h00);

    // R11 table write in same cycle as request is not seen by that request
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 5'd9; tbl_valid = 1'b1;
    tbl_phys_id = 8'h19; tbl_log_dest = 8'h00; tbl_model = 4'hF;
    set_req(8'h19, 1'b0, 2'd0, 5'd0, 3'd0, 8'h77, 1'b0, 1'b1);
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    chk("R11", "same-cycle write irq_hit", irq_hit, 32'h0);
    send(8'h19, 1'b0, 2'd0, 5'd0, 3'd0, 8'h77, 1'b0, 1'b1);
    chk("R1", "new entry irq_hit", irq_hit, 32'h0000_0200);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule